// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM that is one million words deep and four bits wide. The host asks for one word at a time through a request/ready handshake and gets read words back with a one-cycle valid strobe. The block turns each request into a sequence of active-low chip-select, output-gate and write-strobe levels on the memory pins. The address is held steady for the whole access, and the shared data bus is split into an output value, a driver enable and an input value.

Every analogue timing figure is a parameter in nanoseconds. It is rounded up to whole clock cycles, and a margin of extra cycles is added. Writes are strobe-timed with the output gate kept high. The block watches the bus direction: when a write follows a read, it waits for the memory's release time before it turns its own drivers on.

Top module: `sram_seq_top`

## Requirements
- R1: While reset is held and in the cycle after it ends, chip select, output gate and write strobe are all high (inactive), the data drivers are off, ready is 1 and rvalid is 0.
- R2: A request is taken on a clock edge where req and ready are both 1. The address, direction and write data are captured at that edge, so changes on the host inputs afterwards do not affect the access. Ready is 0 from the next cycle until the access completes.
- R3: During a write, chip select is low and the output gate stays high. The write strobe is low for exactly WE_CYC consecutive cycles, where WE_CYC = max(ceil(T_PWE_NS/CLK_NS), ceil(T_DS_NS/CLK_NS)) + MARGIN.
- R4: While the write strobe is low, the data drivers are on and carry the captured write data, and that value is what the memory stores.
- R5: The data drivers are never on while the output gate is low. A write whose previous access was a read spends HZ_CYC = ceil(T_HZ_NS/CLK_NS) cycles with chip select low and every strobe high before the write strobe falls.
- R6: A write that follows a write, or the first access after reset, lowers the write strobe in the first cycle after it is taken.
- R7: A read holds chip select and output gate low with the write strobe high for exactly AA_CYC = ceil(T_AA_NS/CLK_NS) + MARGIN cycles. The memory data is captured at the edge that ends this window, and rvalid is high for exactly one cycle with that word on rdata.
- R8: The memory address does not change while chip select stays low. In the cycle after the write strobe rises, chip select is still low and the address is unchanged.
- R9: Ready returns after turn + WE_CYC + 1 busy cycles for a write (turn being 0 or HZ_CYC) and after AA_CYC busy cycles for a read. For a read it rises in the same cycle as rvalid.
- R10: Whenever ready is 1, chip select, output gate and write strobe are high and the drivers are off, so the memory stays in standby between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host word address |
| req_wdata | input | DATA_W | Host write data |
| ready | output | 1 | Block idle, request may be taken |
| rdata | output | DATA_W | Captured read word |
| rvalid | output | 1 | One-cycle strobe, rdata valid |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| dq_out | output | DATA_W | Value driven onto the data bus |
| dq_oe | output | 1 | Data bus driver enable |
| dq_in | input | DATA_W | Value sensed on the data bus |

## Verification
Completing a read and taking a write can happen in the same cycle. Rvalid and ready rise together, and a request already waiting is taken at the next edge while the output gate has only just gone high. The bench provokes this by issuing a write at once after every read across the whole address space of a 6-bit configuration. It judges the write by the cycle in which the write strobe falls, which must be HZ_CYC later than for a write that follows a write. A monitor counts every cycle with drivers on while the gate is low, and a read-back of the new value confirms that the write landed.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_TURN   = 3'd1,
    SQ_WPULSE = 3'd2,
    SQ_WHOLD  = 3'd3,
    SQ_RACC   = 3'd4
  } sq_state_e;

  // whole cycles covering a time in ns, rounded up
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned maxval);
    int unsigned w;
    w = 1;
    while ((1 << w) <= maxval) w++;
    return w;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned HZ_CYC = 1,
  parameter int unsigned WE_CYC = 2,
  parameter int unsigned AA_CYC = 2,
  parameter int unsigned CW     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_we,
  input  logic          tmr_zero,
  output sq_state_e     state,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          acc_fire,
  output logic          rd_done,
  output logic          wr_start,
  output logic          turn_needed
);
  localparam logic [CW-1:0] HZ_LD = CW'(max_u(HZ_CYC, 1) - 1);
  localparam logic [CW-1:0] WE_LD = CW'(WE_CYC - 1);
  localparam logic [CW-1:0] AA_LD = CW'(AA_CYC - 1);
  localparam bit USE_TURN = (HZ_CYC > 0);

  sq_state_e nxt;
  logic      bus_hot;   // last access was a read, memory may still drive

  assign acc_fire    = (state == SQ_IDLE) && req;
  assign turn_needed = acc_fire && req_we && bus_hot && USE_TURN;
  assign rd_done     = (state == SQ_RACC) && tmr_zero;
  assign wr_start    = (nxt == SQ_WPULSE) && (state != SQ_WPULSE);

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      SQ_IDLE: begin
        if (acc_fire) begin
          tmr_load = 1'b1;
          if (!req_we) begin
            nxt     = SQ_RACC;
            tmr_val = AA_LD;
          end else if (turn_needed) begin
            nxt     = SQ_TURN;
            tmr_val = HZ_LD;
          end else begin
            nxt     = SQ_WPULSE;
            tmr_val = WE_LD;
          end
        end
      end
      SQ_TURN: begin
        if (tmr_zero) begin
          nxt      = SQ_WPULSE;
          tmr_load = 1'b1;
          tmr_val  = WE_LD;
        end
      end
      SQ_WPULSE: if (tmr_zero) nxt = SQ_WHOLD;
      SQ_WHOLD:  nxt = SQ_IDLE;
      SQ_RACC:   if (tmr_zero) nxt = SQ_IDLE;
      default:   nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      bus_hot <= 1'b0;
    end else begin
      state <= nxt;
      if (rd_done)                                    bus_hot <= 1'b1;
      else if (state == SQ_WPULSE || wr_start)        bus_hot <= 1'b0;
    end
  end
endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_fire,
  input  logic              rd_done,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      rvalid  <= 1'b0;
    end else begin
      if (acc_fire) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      rvalid <= rd_done;
      if (rd_done) rdata <= dq_in;
    end
  end
endmodule

// File: rtl/sram_seq_top.sv
module sram_seq_top
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 4,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_AA_NS   = 10,
  parameter int unsigned T_PWE_NS  = 7,
  parameter int unsigned T_DS_NS   = 5,
  parameter int unsigned T_HZ_NS   = 5,
  parameter int unsigned MARGIN    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);
  localparam int unsigned HZ_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned WE_CYC = max_u(ns_to_cyc(T_PWE_NS, CLK_NS),
                                         ns_to_cyc(T_DS_NS, CLK_NS)) + MARGIN;
  localparam int unsigned AA_CYC = ns_to_cyc(T_AA_NS, CLK_NS) + MARGIN;
  localparam int unsigned CW     = cnt_width(max_u(max_u(HZ_CYC, WE_CYC), AA_CYC));

  sq_state_e     state;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic          acc_fire, rd_done, wr_start, turn_needed;
  logic [DATA_W-1:0] wdata_q;

  sram_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sram_seq_fsm #(
    .HZ_CYC(HZ_CYC), .WE_CYC(WE_CYC), .AA_CYC(AA_CYC), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .tmr_zero(tmr_zero),
    .state(state), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .acc_fire(acc_fire), .rd_done(rd_done), .wr_start(wr_start),
    .turn_needed(turn_needed)
  );

  sram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .acc_fire(acc_fire), .rd_done(rd_done),
    .req_addr(req_addr), .req_wdata(req_wdata), .dq_in(dq_in),
    .addr_q(mem_addr), .wdata_q(wdata_q), .rdata(rdata), .rvalid(rvalid)
  );

  // pin levels decoded from the registered state only
  always_comb begin
    ready    = (state == SQ_IDLE);
    mem_ce_n = (state == SQ_IDLE);
    mem_oe_n = (state != SQ_RACC);
    mem_we_n = (state != SQ_WPULSE);
    dq_oe    = (state == SQ_WPULSE) || (state == SQ_WHOLD);
    dq_out   = wdata_q;
  end
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned HZ_CYC = 1,
  parameter int unsigned WE_CYC = 2,
  parameter int unsigned AA_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              rvalid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              dq_oe,
  input logic              acc_fire
);
  logic [7:0] oe_hi_cnt, oe_lo_cnt, we_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_hi_cnt <= 8'hff;
      oe_lo_cnt <= '0;
      we_lo_cnt <= '0;
    end else begin
      oe_hi_cnt <= !mem_oe_n ? 8'd0 : (oe_hi_cnt == 8'hff ? oe_hi_cnt : oe_hi_cnt + 8'd1);
      oe_lo_cnt <=  mem_oe_n ? 8'd0 : oe_lo_cnt + 8'd1;
      we_lo_cnt <=  mem_we_n ? 8'd0 : we_lo_cnt + 8'd1;
    end
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !dq_oe)); // R10
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    acc_fire |=> !ready); // R2
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo_cnt == 8'(WE_CYC))); // R3
  AST_WE_FRAME: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && dq_oe)); // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> mem_oe_n); // R5
  AST_DRIVE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> (oe_hi_cnt >= 8'(HZ_CYC))); // R5
  AST_READ_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_lo_cnt == 8'(AA_CYC))); // R7
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R8
  AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> !mem_ce_n); // R8
endmodule

bind sram_seq_top sram_seq_chk #(
  .ADDR_W(ADDR_W), .HZ_CYC(HZ_CYC), .WE_CYC(WE_CYC), .AA_CYC(AA_CYC)
) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .rvalid(rvalid), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .dq_oe(dq_oe), .acc_fire(acc_fire)
);

// File: tb/test_sram_seq_top.sv
module test_sram_seq_top;
  localparam int AW = 6;
  localparam int DW = 4;
  localparam int CLK_NS = 8;

  function automatic int cdiv(input int a, input int b);
    return a / b + ((a % b) != 0 ? 1 : 0);
  endfunction
  localparam int E_HZ = cdiv(5, CLK_NS);
  localparam int E_WE = ((cdiv(7, CLK_NS) > cdiv(5, CLK_NS)) ? cdiv(7, CLK_NS) : cdiv(5, CLK_NS)) + 1;
  localparam int E_AA = cdiv(10, CLK_NS) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ready, rvalid, mem_ce_n, mem_oe_n, mem_we_n, dq_oe;
  logic [DW-1:0] rdata, dq_out, dq_in;
  logic [AW-1:0] mem_addr;

  always #4 clk = ~clk;

  sram_seq_top #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_NS)) i_sram_seq_top (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rdata(rdata), .rvalid(rvalid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  // memory model: stores on the rising write strobe while selected
  logic [DW-1:0] mem [1 << AW];
  initial for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
  always @(posedge mem_we_n) if (!rst && !mem_ce_n && dq_oe) mem[mem_addr] <= dq_out;
  assign dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem[mem_addr] : 4'hx;

  int total = 0, fails = 0;
  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // run-long monitors
  int contention = 0, addr_moves = 0, rv_long = 0;
  logic prev_ce_low = 1'b0, prev_rv = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (dq_oe && !mem_oe_n) contention++;
      if (!mem_ce_n && prev_ce_low && mem_addr != prev_addr) addr_moves++;
      if (rvalid && prev_rv) rv_long++;
    end
    prev_ce_low = !mem_ce_n;
    prev_addr   = mem_addr;
    prev_rv     = rvalid;
  end

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 5 + 3 + k * 7) ^ (a >> 2));
  endfunction

  // called at a negedge with ready high; returns at the negedge where ready is high again
  task automatic do_write(input int a, input logic [DW-1:0] d, input bit after_rd);
    int n = 0, first_lo = -1, lo_len = 0, bad_data = 0, oe_low = 0;
    int turn = after_rd ? E_HZ : 0;
    req = 1; req_we = 1; req_addr = AW'(a); req_wdata = d;
    do begin
      @(negedge clk); n++;
      if (n == 1) begin req = 0; req_addr = ~AW'(a); req_wdata = ~d; end // R2 captured at accept
      if (!mem_we_n) begin
        if (first_lo < 0) first_lo = n;
        lo_len++;
        if (!dq_oe || dq_out !== d) bad_data++;
        if (mem_ce_n) bad_data++;
      end
      if (!mem_oe_n) oe_low++;
    end while (!ready && n < 100);
    check(first_lo == turn + 1, after_rd ? "R5" : "R6", first_lo, turn + 1);
    check(lo_len == E_WE, "R3", lo_len, E_WE);
    check(oe_low == 0, "R3", oe_low, 0);
    check(bad_data == 0, "R4", bad_data, 0);
    check(n == turn + E_WE + 2, "R9", n, turn + E_WE + 2);
  endtask

  task automatic do_read(input int a, input logic [DW-1:0] exp);
    int n = 0, oe_low = 0;
    bit rdy_at_rv = 0;
    req = 1; req_we = 0; req_addr = AW'(a);
    do begin
      @(negedge clk); n++;
      if (n == 1) begin req = 0; req_addr = ~AW'(a); end
      if (!mem_oe_n && !mem_ce_n && mem_we_n) oe_low++;
      if (rvalid) rdy_at_rv = ready;
    end while (!rvalid && n < 100);
    check(rdata === exp, "R7", int'(rdata), int'(exp));
    check(oe_low == E_AA, "R7", oe_low, E_AA);
    check(n == E_AA + 1 && rdy_at_rv, "R9", n, E_AA + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !dq_oe && ready && !rvalid, "R1",
          {mem_ce_n, mem_oe_n, mem_we_n, dq_oe, ready, rvalid}, 6'b111010);
    rst = 0;
    @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !dq_oe && ready && !rvalid, "R1",
          {mem_ce_n, mem_oe_n, mem_we_n, dq_oe, ready, rvalid}, 6'b111010);
    check(ready && mem_ce_n, "R10", int'(mem_ce_n), 1);

    // write sweep, writes back to back (no turnaround)
    for (int a = 0; a < (1 << AW); a++) do_write(a, pat(a, 0), 1'b0);
    // read sweep
    for (int a = 0; a < (1 << AW); a++) do_read(a, pat(a, 0));
    // read then write in the completion cycle, then confirm
    for (int a = 0; a < (1 << AW); a++) begin
      do_read(a, pat(a, 0));
      do_write(a, pat(a, 1), 1'b1);
      do_read(a, pat(a, 1));
    end
    // idle gap after a read still gets a turnaround
    do_read(5, pat(5, 1));
    repeat (5) @(negedge clk);
    check(ready && mem_ce_n && mem_oe_n && mem_we_n && !dq_oe, "R10", int'(ready), 1);
    do_write(5, pat(5, 2), 1'b1);
    do_write(6, pat(6, 2), 1'b0);
    do_read(5, pat(5, 2));
    do_read(6, pat(6, 2));

    check(contention == 0, "R5", contention, 0);
    check(addr_moves == 0, "R8", addr_moves, 0);
    check(rv_long == 0, "R7", rv_long, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule